// File: doc/BRIEF.md
# Programmable Power-Save Clock Scaler

This block runs in the oscillator clock domain and produces the timing references a processor core needs: a one-cycle enable that marks the start of each internal CPU clock period, a CPU-rate square wave for the outside world, and an enable that marks each period of a faster external clock. A two-bit scaling code slows all three by a factor of 1, 2, 4 or 8. At factor 1 the CPU-rate clock runs at half the oscillator rate. Lowering the rate when little computation is needed saves power.

The code is made of a C bit (upper) and an M bit (lower). Software loads it through a configuration-write strobe. The write takes hold only when the processor reports supervisor mode at the same time. An accepted code waits until the current CPU period has completed and only then becomes active, so no output pulse is ever cut short. A read-back port shows the code that is currently active.

A synchronous reset selects full speed. While reset is held, the CPU-rate outputs stay low and the fast-clock enable is high on every oscillator cycle.

Top module: `pss_clock_scaler`

## Requirements
- R1: `code_rd` shows the active code as {C,M}. Code value k (00, 01, 10, 11) selects the scaling factor F = 2^k, that is 1, 2, 4 or 8.
- R2: Outside reset, `cpu_clk` has a period of 2F oscillator cycles. It is high for the first F cycles of each period and low for the last F. `cpu_ce` is high for exactly the first cycle of each period.
- R3: While `rst` is sampled high, `code_rd` reads 00 and `cpu_clk` and `cpu_ce` are low. At the first clock edge after `rst` is released, a new period starts at factor 1.
- R4: A write with `cfg_wr` high and `supervisor` low changes neither the active code nor any code still waiting, so the output timing is unaffected.
- R5: While `rst` is sampled high, `fast_ce` is high on every oscillator cycle.
- R6: A code accepted in supervisor mode becomes active at the next period start. It does not take effect sooner. `code_rd` and the output rates change in the same cycle in which `cpu_ce` is high.
- R7: Outside reset, `fast_ce` is high once every F cycles, on the cycles where the position within the period is a multiple of F. It is therefore always high together with `cpu_ce`.
- R8: A supervisor write in the last cycle of a period is deferred to the period start after that. Of several supervisor writes before one period start, the last one wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration-write strobe for the scaling code |
| cfg_code | input | CODE_W (2) | Code to write, {C,M} |
| supervisor | input | 1 | High when the processor is in supervisor mode |
| cpu_ce | output | 1 | One-cycle enable at the start of each CPU clock period |
| cpu_clk | output | 1 | CPU-rate clock output, oscillator/(2F) |
| fast_ce | output | 1 | Fast-clock enable, oscillator/F (every cycle while in reset) |
| code_rd | output | CODE_W (2) | Active scaling code, {C,M} |

## Verification
A wrong internal phase count shows within one CPU period as a misplaced `cpu_ce` or a `cpu_clk` edge that falls on the wrong cycle. A wrong active code shows on `code_rd` at once and in the rate of `fast_ce` within F cycles. A lost or early pending code shows at the first period start after the write: `code_rd` moves one period too soon or too late. The bench sweeps every pair of old and new codes, with the supervisor write placed at every phase of the old period. It compares all four outputs in every cycle against a model that works from phase arithmetic alone.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // Encoding of the scaling code: bit 1 = C, bit 0 = M; value k -> factor 2^k
  localparam int unsigned SCALE_CODE_W = 2;
  localparam int unsigned SCALE_MAX_SHIFT = (1 << SCALE_CODE_W) - 1;

  typedef logic [SCALE_CODE_W-1:0] scale_code_t;

  // Width of a phase counter able to hold one full period at the slowest rate
  function automatic int unsigned phase_width(input int unsigned max_shift);
    return max_shift + 1;
  endfunction
endpackage

// File: rtl/pss_cfg_gate.sv
module pss_cfg_gate #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              supervisor,
  input  logic              at_end,
  output logic [CODE_W-1:0] pend_code,
  output logic              pend_valid
);
  logic wr_ok;

  // Only writes made in supervisor mode are accepted
  assign wr_ok = cfg_wr & supervisor;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_code  <= '0;
      pend_valid <= 1'b0;
    end else if (wr_ok) begin
      // the last accepted write wins; a write at a period end stays pending (R8)
      pend_code  <= cfg_code;
      pend_valid <= 1'b1;
    end else if (at_end) begin
      pend_valid <= 1'b0;
    end
  end

  p_user_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !supervisor) |=> $stable(pend_code));

  p_pending_set_on_write_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && supervisor) |=> (pend_valid && pend_code == $past(cfg_code)));
endmodule

// File: rtl/pss_period_ctr.sv
module pss_period_ctr #(
  parameter int unsigned MAX_SHIFT = 3,
  parameter int unsigned CODE_W    = 2,
  parameter int unsigned CNT_W     = MAX_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] pend_code,
  input  logic              pend_valid,
  output logic              at_end,
  output logic [CNT_W-1:0]  cnt_n,
  output logic [CODE_W-1:0] act_n,
  output logic [CODE_W-1:0] act_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // Last phase of a period at the active rate: 2F-1
  always_comb begin
    last   = CNT_W'((2 << act_q) - 1);
    at_end = (cnt_q == last);
    cnt_n  = at_end ? '0 : cnt_q + 1'b1;
    act_n  = (at_end && pend_valid) ? pend_code : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      // park at the last phase of a factor-1 period so release starts a period
      cnt_q <= CNT_W'(1);
      act_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  p_phase_in_period_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);

  p_code_hold_mid_period_r6: assert property (@(posedge clk) disable iff (rst)
    !at_end |=> $stable(act_q));
endmodule

// File: rtl/pss_clk_gen.sv
module pss_clk_gen #(
  parameter int unsigned MAX_SHIFT = 3,
  parameter int unsigned CODE_W    = 2,
  parameter int unsigned CNT_W     = MAX_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_n,
  input  logic [CODE_W-1:0] act_n,
  output logic              cpu_ce,
  output logic              cpu_clk,
  output logic              fast_ce
);
  logic [MAX_SHIFT:0] aligned;
  logic [CNT_W-1:0]   half;

  // aligned[s]: next phase is a multiple of 2^s
  for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_align
    if (s == 0) begin : g_any
      assign aligned[s] = 1'b1;
    end else begin : g_low
      assign aligned[s] = (cnt_n[s-1:0] == '0);
    end
  end

  assign half = CNT_W'(1) << act_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk <= 1'b0;
      cpu_ce  <= 1'b0;
      fast_ce <= 1'b1;
    end else begin
      cpu_clk <= (cnt_n < half);
      cpu_ce  <= (cnt_n == '0);
      fast_ce <= aligned[act_n];
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d == 1'b1) begin
      p_fast_in_reset_r5: assert (fast_ce && !cpu_ce && !cpu_clk);
    end
  end

  p_ce_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |-> (cpu_clk && !$past(cpu_clk)));

  p_rise_has_ce_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk) |-> cpu_ce);

  p_ce_implies_fast_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |-> fast_ce);
endmodule

// File: rtl/pss_clock_scaler.sv
module pss_clock_scaler
  import pss_pkg::*;
#(
  parameter int unsigned MAX_SHIFT = SCALE_MAX_SHIFT,
  parameter int unsigned CODE_W    = $clog2(MAX_SHIFT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              supervisor,
  output logic              cpu_ce,
  output logic              cpu_clk,
  output logic              fast_ce,
  output logic [CODE_W-1:0] code_rd
);
  localparam int unsigned CNT_W = phase_width(MAX_SHIFT);

  logic [CODE_W-1:0] pend_code;
  logic              pend_valid;
  logic              at_end;
  logic [CNT_W-1:0]  cnt_n;
  logic [CODE_W-1:0] act_n;
  logic [CODE_W-1:0] act_q;

  pss_cfg_gate #(.CODE_W(CODE_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_code   (cfg_code),
    .supervisor (supervisor),
    .at_end     (at_end),
    .pend_code  (pend_code),
    .pend_valid (pend_valid)
  );

  pss_period_ctr #(.MAX_SHIFT(MAX_SHIFT), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .pend_code  (pend_code),
    .pend_valid (pend_valid),
    .at_end     (at_end),
    .cnt_n      (cnt_n),
    .act_n      (act_n),
    .act_q      (act_q)
  );

  pss_clk_gen #(.MAX_SHIFT(MAX_SHIFT), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .cnt_n   (cnt_n),
    .act_n   (act_n),
    .cpu_ce  (cpu_ce),
    .cpu_clk (cpu_clk),
    .fast_ce (fast_ce)
  );

  assign code_rd = act_q;

  p_code_moves_with_ce_r6: assert property (@(posedge clk) disable iff (rst)
    (code_rd != $past(code_rd)) |-> cpu_ce);

  p_reset_full_speed_r3: assert property (@(posedge clk)
    rst |=> (code_rd == '0));
endmodule

// File: tb/pss_clock_scaler_tb.sv
module pss_clock_scaler_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_code = 2'b00;
  logic       supervisor = 1'b0;
  logic       cpu_ce, cpu_clk, fast_ce;
  logic [1:0] code_rd;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit chk_en = 1'b0;
  string scen = "reset";

  always #4 clk = ~clk;  // 125 MHz

  pss_clock_scaler u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
    .supervisor(supervisor), .cpu_ce(cpu_ce), .cpu_clk(cpu_clk),
    .fast_ce(fast_ce), .code_rd(code_rd)
  );

  // Reference: phase within period and active/waiting code, from R1..R8
  int m_ph = 1, m_act = 0, m_pend = 0;
  bit m_pv = 0;
  bit e_clk = 0, e_ce = 0, e_fast = 1;
  bit m_rst = 1;

  always @(posedge clk) begin
    m_rst = rst;
    if (rst) begin
      m_ph = 1; m_act = 0; m_pv = 0; m_pend = 0;
      e_clk = 0; e_ce = 0; e_fast = 1;
    end else begin
      int f;
      bit fin;
      f = 1 << m_act;
      fin = (m_ph == 2 * f - 1);
      if (fin) begin
        m_ph = 0;
        if (m_pv) m_act = m_pend;
        m_pv = 0;
      end else begin
        m_ph = m_ph + 1;
      end
      if (cfg_wr && supervisor) begin m_pend = cfg_code; m_pv = 1; end
      f = 1 << m_act;
      e_clk  = (m_ph < f);
      e_ce   = (m_ph == 0);
      e_fast = ((m_ph % f) == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(m_rst ? "R3 cpu_clk" : "R2 cpu_clk", cpu_clk, e_clk);
      check(m_rst ? "R3 cpu_ce"  : "R2 cpu_ce",  cpu_ce,  e_ce);
      check(m_rst ? "R5 fast_ce" : "R7 fast_ce", fast_ce, e_fast);
      check(m_rst ? "R3 code_rd" : "R1/R6 code_rd", code_rd, m_act);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] code, input logic sup);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_code = code; supervisor = sup;
    @(negedge clk);
    cfg_wr = 1'b0; supervisor = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    // R3/R5: reset state and fast enable on every cycle
    @(negedge clk);
    chk_en = 1'b1;
    idle(5);
    rst = 1'b0;
    scen = "R3 release at factor 1";
    idle(12);

    // R6/R7/R1: every old/new code pair, write at every phase of the old period;
    // R4: a user-mode write of a different code in between must change nothing
    for (int from = 0; from < 4; from++) begin
      for (int to = 0; to < 4; to++) begin
        for (int off = 0; off < 16; off++) begin
          scen = $sformatf("R6 %0d->%0d off%0d", from, to, off);
          cfg_write(2'(from), 1'b1);
          idle(34);
          scen = "R4 user write ignored";
          cfg_write(2'(3 - to), 1'b0);
          idle(off);
          scen = $sformatf("R6 %0d->%0d off%0d", from, to, off);
          cfg_write(2'(to), 1'b1);
          idle(34);
        end
      end
    end

    // R8: back-to-back supervisor writes, the last one wins
    scen = "R8 last write wins";
    cfg_write(2'b11, 1'b1);
    cfg_write(2'b01, 1'b1);
    cfg_write(2'b10, 1'b1);
    idle(40);

    // R3: reset in the middle of a slow period returns to full speed
    scen = "R3 mid-period reset";
    cfg_write(2'b11, 1'b1);
    idle(25);
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(10);

    chk_en = 1'b0;
    finish_run();
  end
endmodule